// File: doc/BRIEF.md
# Strap-addressed I2C register bank target

This block is an I2C target that lets a bus host read and write a bank of four 8-bit registers. It watches SCL and SDA, which arrive already synchronised to the local clock. It pulls SDA low through an open-drain enable output. The register contents leave the block as one flat parallel bus, for use by downstream logic.

The 7-bit target address is 1 0 0 1 0 S1 S0. The two low bits come from static strap inputs, so up to four copies can share one bus.

A host uses the bank as follows:
- To write, the host sends the address with a write bit, then a pointer byte, then one data byte.
- To read, the host sets the pointer the same way, issues a repeated start, and sends the address with a read bit. The block then shifts out the selected register.

A high-speed master code (byte pattern 00001xxx) is never acknowledged. The repeated start that follows it puts the block into high-speed mode. The block stays in that mode until a STOP.

Top module: `i2c_regfile_target`

## Requirements
- R1: The block acknowledges a first byte whose upper seven bits equal {1,0,0,1,0,strap_i[1],strap_i[0]}, by driving sda_oe_o high during the ninth clock. Any other address is left unacknowledged. Bit 0 of that byte selects write (0) or read (1).
- R2: After an acknowledged write address, the block acknowledges a pointer byte 000000 P1 P0 and stores P1:P0 as the register pointer.
- R3: A pointer byte with any of bits 7..2 set is not acknowledged, and the stored pointer keeps its previous value.
- R4: A data byte after an acknowledged pointer is acknowledged. It is written to register P only when SCL falls at the end of that acknowledge. Register k appears on regs_o[8k+7:8k].
- R5: After an acknowledged read address, the block drives the pointed register MSB first, one bit per SCL low phase. It releases SDA for the host's acknowledge bit.
- R6: A first byte of the form 00001xxx is not acknowledged, and high_speed_o rises on the next repeated start. high_speed_o stays high across later repeated starts and falls on STOP.
- R7: A START or STOP in the middle of a byte discards that byte. It releases SDA and returns the block to waiting for an address.
- R8: After reset, all registers read 0x00, the pointer is 0, and high_speed_o and sda_oe_o are low.
- R9: sda_oe_o changes only after an SCL falling edge, or when a START or STOP clears it. It never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| strap_i | input | 2 | Static low address bits |
| sda_oe_o | output | 1 | High pulls SDA low |
| high_speed_o | output | 1 | High-speed mode flag |
| regs_o | output | 32 | Register k at bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: four registers of eight bits and a fixed address prefix of 10010. With these values all four pointer codes, a pointer byte with illegal upper bits, and both strap settings that the bench drives can be reached within a short run. The bus host runs SCL at sixteen local clocks per bit. This leaves room to see every registered change of sda_oe_o inside a single SCL phase. It also lets the bench place START and STOP conditions in the middle of a byte, and surround a high-speed master code with repeated starts.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_ACK, ST_RDATA, ST_HACK, ST_SKIP
  } eng_state_e;

  typedef enum logic [1:0] {
    ACT_TO_PTR, ACT_SET_PTR, ACT_WRITE, ACT_TO_READ
  } ack_act_e;

  localparam logic [4:0] HS_PREFIX     = 5'b00001;
  localparam logic [4:0] ADDR_FIXED_DF = 5'b10010;
endpackage

// File: rtl/i2c_rf_line_sense.sv
module i2c_rf_line_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_rf_reg_bank.sv
module i2c_rf_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [PTR_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [PTR_W-1:0]           rd_idx_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] bank_q [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  bank_q[k] <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(k))    bank_q[k] <= wr_data_i;
    end
    assign flat_o[k*DATA_W +: DATA_W] = bank_q[k];
  end

  assign rd_data_o = bank_q[rd_idx_i];
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PTR_W   = 2,
  parameter int STRAP_W = 2,
  parameter int ADDR_W  = 7,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_FIXED = ADDR_FIXED_DF,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               wr_en_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               sda_oe_o,
  output logic               high_speed_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  eng_state_e        state_q;
  ack_act_e          act_q, byte_act;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              oe_q, hs_q, hs_pend_q;
  logic              byte_ok, addr_hit, hs_code, ptr_ok;

  assign addr_hit = shreg_q[DATA_W-1 -: ADDR_W] == {ADDR_FIXED, strap_i};
  assign hs_code  = shreg_q[DATA_W-1 -: 5] == HS_PREFIX;
  assign ptr_ok   = shreg_q[DATA_W-1:PTR_W] == '0;

  always_comb begin
    byte_ok  = 1'b0;
    byte_act = ACT_TO_PTR;
    unique case (state_q)
      ST_ADDR: begin
        byte_ok  = addr_hit;
        byte_act = shreg_q[0] ? ACT_TO_READ : ACT_TO_PTR;
      end
      ST_PTR: begin
        byte_ok  = ptr_ok;
        byte_act = ACT_SET_PTR;
      end
      ST_WDATA: begin
        byte_ok  = 1'b1;
        byte_act = ACT_WRITE;
      end
      default: ;
    endcase
  end

  // commit lands on the falling edge that ends the acknowledge
  assign wr_en_o   = (state_q == ST_ACK) && scl_fall_i && (act_q == ACT_WRITE)
                     && !start_i && !stop_i;
  assign wr_data_o = shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      act_q     <= ACT_TO_PTR;
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      hs_q      <= 1'b0;
      hs_pend_q <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
      hs_q      <= 1'b0;
      hs_pend_q <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
      hs_pend_q <= 1'b0;
      if (hs_pend_q) hs_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise_i && bit_cnt_q != FULL) begin
            shreg_q   <= {shreg_q[DATA_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall_i && bit_cnt_q == FULL) begin
            bit_cnt_q <= '0;
            if (byte_ok) begin
              oe_q    <= 1'b1;
              act_q   <= byte_act;
              state_q <= ST_ACK;
            end else begin
              state_q <= ST_SKIP;
              if (state_q == ST_ADDR && hs_code) hs_pend_q <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            oe_q <= 1'b0;
            unique case (act_q)
              ACT_TO_PTR:  state_q <= ST_PTR;
              ACT_SET_PTR: begin
                ptr_q   <= shreg_q[PTR_W-1:0];
                state_q <= ST_WDATA;
              end
              ACT_WRITE:   state_q <= ST_SKIP;
              ACT_TO_READ: begin
                shreg_q <= rd_data_i;
                oe_q    <= ~rd_data_i[DATA_W-1];
                state_q <= ST_RDATA;
              end
              default:     state_q <= ST_SKIP;
            endcase
          end
        end
        ST_RDATA: begin
          if (scl_rise_i && bit_cnt_q != FULL) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall_i && bit_cnt_q == FULL) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_HACK;
          end else if (scl_fall_i && bit_cnt_q != '0) begin
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            oe_q    <= ~shreg_q[DATA_W-2];
          end
        end
        ST_HACK: if (scl_fall_i) state_q <= ST_SKIP;
        default: ;
      endcase
    end
  end

  assign ptr_o        = ptr_q;
  assign sda_oe_o     = oe_q;
  assign high_speed_o = hs_q;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_rf_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int STRAP_W  = 2,
  parameter int ADDR_W   = 7,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_FIXED = ADDR_FIXED_DF,
  localparam int PTR_W   = $clog2(NUM_REGS),
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic               high_speed_o,
  output logic [FLAT_W-1:0]  regs_o
);
  logic              start_w, stop_w, rise_w, fall_w, wr_en_w;
  logic [PTR_W-1:0]  ptr_w;
  logic [DATA_W-1:0] wr_data_w, rd_data_w;

  i2c_rf_line_sense u_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w)
  );

  i2c_rf_engine #(
    .DATA_W     (DATA_W),
    .PTR_W      (PTR_W),
    .STRAP_W    (STRAP_W),
    .ADDR_W     (ADDR_W),
    .ADDR_FIXED (ADDR_FIXED)
  ) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_i        (sda_i),
    .start_i      (start_w),
    .stop_i       (stop_w),
    .scl_rise_i   (rise_w),
    .scl_fall_i   (fall_w),
    .strap_i      (strap_i),
    .rd_data_i    (rd_data_w),
    .ptr_o        (ptr_w),
    .wr_en_o      (wr_en_w),
    .wr_data_o    (wr_data_w),
    .sda_oe_o     (sda_oe_o),
    .high_speed_o (high_speed_o)
  );

  i2c_rf_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_w),
    .wr_idx_i  (ptr_w),
    .wr_data_i (wr_data_w),
    .rd_idx_i  (ptr_w),
    .rd_data_o (rd_data_w),
    .flat_o    (regs_o)
  );
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
  parameter int FLAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe_o,
  input logic              high_speed_o,
  input logic [FLAT_W-1:0] regs_o
);
  logic scl_d, sda_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  logic c_start, c_stop, c_fall;
  assign c_start = scl_d && scl_i && sda_d && !sda_i;
  assign c_stop  = scl_d && scl_i && !sda_d && sda_i;
  assign c_fall  = scl_d && !scl_i;

  assert_regs_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_fall |=> $stable(regs_o));

  assert_oe_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!c_fall && !c_start && !c_stop) |=> $stable(sda_oe_o));

  assert_stop_exits_hs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_stop |=> (!high_speed_o && !sda_oe_o));

  assert_hs_rise_on_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(high_speed_o) |-> $past(c_start));

  assert_start_releases_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_start |=> !sda_oe_o);
endmodule

bind i2c_regfile_target i2c_rf_checker #(.FLAT_W(FLAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_i        (scl_i),
  .sda_i        (sda_i),
  .sda_oe_o     (sda_oe_o),
  .high_speed_o (high_speed_o),
  .regs_o       (regs_o)
);

// File: tb/i2c_regfile_target_bench.sv
module i2c_regfile_target_bench;
  localparam int Q = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_h = 1'b1, sda_h = 1'b1;
  logic [1:0]  strap = 2'b10;
  logic        sda_oe, hs;
  logic [31:0] regs;
  logic        sda_bus;

  assign sda_bus = sda_h & ~sda_oe;
  always #10 clk = ~clk;

  i2c_regfile_target u_i2c_regfile_target (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_h),
    .sda_i        (sda_bus),
    .strap_i      (strap),
    .sda_oe_o     (sda_oe),
    .high_speed_o (hs),
    .regs_o       (regs)
  );

  typedef struct {
    string       req;
    string       what;
    logic [31:0] exp;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] act_q[$];
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;
  int          r9_viol = 0;
  logic [7:0]  mdl [4];

  task automatic expect_item(input string req, input string what, input logic [31:0] e, input logic [31:0] a);
    exp_q.push_back('{req, what, e});
    act_q.push_back(a);
  endtask

  // monitor: pops and compares
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        exp_t        e;
        logic [31:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_cmp++;
        if (a !== e.exp) begin
          n_bad++;
          $display("FAIL %s %s: actual %h expected %h", e.req, e.what, a, e.exp);
        end
      end
    end
  end

  // R9 observer: oe must not move while SCL stays high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_scl && scl_h && (sda_oe !== prev_oe)) r9_viol++;
    prev_scl = scl_h;
    prev_oe  = sda_oe;
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; qw();
    sda_h = 1'b0; qw();
    scl_h = 1'b0; qw();
  endtask

  task automatic bus_rstart();
    sda_h = 1'b1; qw();
    scl_h = 1'b1; qw();
    sda_h = 1'b0; qw();
    scl_h = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; qw();
    scl_h = 1'b1; qw();
    sda_h = 1'b1; qw();
  endtask

  task automatic wbit(input logic b);
    sda_h = b; qw();
    scl_h = 1'b1; qw(); qw();
    scl_h = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    sda_h = 1'b1; qw();
    scl_h = 1'b1; qw();
    b = sda_bus; qw();
    scl_h = 1'b0; qw();
  endtask

  task automatic snd(input logic [7:0] v, output logic acked);
    logic ab;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(ab);
    acked = ~ab;
  endtask

  task automatic rcv(output logic [7:0] v, input logic host_ack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      rbit(b);
      v[i] = b;
    end
    wbit(~host_ack);
  endtask

  function automatic logic [7:0] adr(input logic [1:0] s, input logic rd);
    return {5'b10010, s, rd};
  endfunction

  function automatic logic [31:0] flat();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  task automatic wr_reg(input int k, input logic [7:0] v);
    logic a;
    bus_start();
    snd(adr(strap, 1'b0), a); expect_item("R1", "write address ack", 1, a);
    snd(8'(k), a);            expect_item("R2", "pointer ack", 1, a);
    snd(v, a);                expect_item("R4", "data ack", 1, a);
    bus_stop();
    mdl[k] = v;
    expect_item("R4", "regs_o after write", flat(), regs);
  endtask

  task automatic rd_reg(input int k);
    logic       a;
    logic [7:0] d;
    bus_start();
    snd(adr(strap, 1'b0), a); expect_item("R2", "address ack", 1, a);
    snd(8'(k), a);            expect_item("R2", "pointer ack", 1, a);
    bus_rstart();
    snd(adr(strap, 1'b1), a); expect_item("R5", "read address ack", 1, a);
    rcv(d, 1'b0);             expect_item("R5", "read byte", {24'h0, mdl[k]}, {24'h0, d});
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic       a;
    logic [7:0] d;
    for (int k = 0; k < 4; k++) mdl[k] = 8'h00;
    repeat (5) @(negedge clk);
    // R8: reset state
    expect_item("R8", "regs after reset", 32'h0, regs);
    expect_item("R8", "high_speed after reset", 0, {31'h0, hs});
    expect_item("R8", "oe after reset", 0, {31'h0, sda_oe});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: pointer 0 after reset, read without pointer write
    bus_start();
    snd(adr(strap, 1'b1), a); expect_item("R1", "read address ack", 1, a);
    rcv(d, 1'b0);             expect_item("R8", "reg0 via reset pointer", 0, {24'h0, d});
    bus_stop();

    wr_reg(0, 8'h3C);
    wr_reg(1, 8'hA5);
    wr_reg(2, 8'h7E);
    wr_reg(3, 8'hC3);
    for (int k = 3; k >= 0; k--) rd_reg(k);

    // R3: bad pointer leaves pointer at 2
    bus_start();
    snd(adr(strap, 1'b0), a); snd(8'h02, a); expect_item("R2", "pointer 2 ack", 1, a);
    bus_stop();
    bus_start();
    snd(adr(strap, 1'b0), a); expect_item("R1", "address ack", 1, a);
    snd(8'h84, a);            expect_item("R3", "bad pointer nack", 0, a);
    bus_stop();
    bus_start();
    snd(adr(strap, 1'b1), a); rcv(d, 1'b0);
    expect_item("R3", "pointer kept after nack", {24'h0, mdl[2]}, {24'h0, d});
    bus_stop();

    // R1: strap mismatch, then strap change
    bus_start();
    snd(adr(2'b01, 1'b0), a); expect_item("R1", "foreign address nack", 0, a);
    bus_stop();
    strap = 2'b01;
    repeat (4) @(negedge clk);
    bus_start();
    snd(adr(2'b01, 1'b0), a); expect_item("R1", "new strap address ack", 1, a);
    bus_stop();
    strap = 2'b10;
    repeat (4) @(negedge clk);

    // R7: STOP mid data byte, no commit
    bus_start();
    snd(adr(strap, 1'b0), a); snd(8'h01, a);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bus_stop();
    expect_item("R7", "regs after aborted byte", flat(), regs);
    expect_item("R7", "oe released after abort", 0, {31'h0, sda_oe});
    // R7: repeated start mid address byte
    bus_start();
    wbit(1'b1); wbit(1'b0); wbit(1'b0);
    bus_rstart();
    snd(adr(strap, 1'b0), a); expect_item("R7", "address after mid-byte Sr", 1, a);
    snd(8'h03, a);            expect_item("R2", "pointer 3 ack", 1, a);
    snd(8'h11, a);            expect_item("R4", "data ack reg3", 1, a);
    bus_stop();
    mdl[3] = 8'h11;
    expect_item("R4", "reg3 after write", flat(), regs);

    // R6: high-speed entry and exit
    bus_start();
    snd(8'h0B, a);            expect_item("R6", "master code nack", 0, a);
    expect_item("R6", "hs before Sr", 0, {31'h0, hs});
    bus_rstart();
    expect_item("R6", "hs after Sr", 1, {31'h0, hs});
    snd(adr(strap, 1'b0), a); expect_item("R6", "hs address ack", 1, a);
    bus_rstart();
    expect_item("R6", "hs across Sr", 1, {31'h0, hs});
    snd(adr(strap, 1'b1), a); rcv(d, 1'b1);
    expect_item("R5", "hs read byte", {24'h0, mdl[3]}, {24'h0, d});
    bus_stop();
    expect_item("R6", "hs after STOP", 0, {31'h0, hs});

    repeat (4) @(negedge clk);
    expect_item("R9", "oe changes with SCL high", 0, r9_viol);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule